// File: doc/BRIEF.md
# Three-Hand Clock Page Replacer

This block chooses which page leaves a fixed-size page buffer when a new page must come in. It approximates a low-reuse-distance policy on a circular table of slots. Every slot carries a page key and a handful of status bits. Three independent pointers walk the same circle in the same direction. The cold pointer looks for a victim. The hot pointer demotes pages that have gone quiet. The test pointer closes reuse-test windows and discards history entries.

A hit costs one cycle and only marks the slot as referenced. A miss holds `req_ready` low while the pointers step one slot per cycle. When the work is done, the block returns one response. The response says whether a page was evicted, gives that page's key, and gives the slot now holding the requested page. The split between hot and cold resident pages moves at run time. Reuse of a recently evicted page grows the cold share. A test window that ends without reuse shrinks it. The current cold share is shown on `cold_budget`. Resident capacity is half the slot count; the other half holds history records of evicted pages.

Top module: `clockpro_replacer`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0, `cold_budget` is 1 and all slots are empty, so the first miss lands in slot 0.
- R2: A request whose key is resident gives a response one cycle later with `resp_hit`=1, `resp_evict`=0 and `resp_slot` equal to that page's slot. The only state it changes is the slot's reference bit.
- R3: A request is taken only while `req_ready` is 1. During a miss, `req_ready` stays 0 until the response, and `req_ready` is 1 whenever `resp_valid` is 1.
- R4: A miss that arrives while fewer than CAP = SLOTS/2 pages are resident evicts nothing (`resp_evict`=0). The new page goes into the lowest-numbered empty slot as a cold page inside a test window.
- R5: A miss that arrives with CAP pages resident starts the cold pointer. It evicts the first resident cold page it finds with reference bit 0 and reports that page's key on `resp_victim` with `resp_evict`=1. If that page was in a test window, its slot stays behind as a history record; otherwise the slot is emptied.
- R6: When the cold pointer meets a resident cold page with reference bit 1, it clears the bit. The page is then promoted to hot if it is in a test window, and otherwise given a new test window.
- R7: While the number of hot pages exceeds CAP minus `cold_budget`, the hot pointer steps before any cold step or response. It clears the reference bit of a hot page that has it set. It demotes a hot page whose bit is 0 to a cold page outside any test window.
- R8: A miss whose key matches a history record makes that slot's page resident and hot, reported in `resp_slot`. It raises `cold_budget` by one, saturating at CAP-1.
- R9: If a miss finds no empty slot, the test pointer steps until one is freed. A cold page in a test window loses the window and `cold_budget` drops by one, saturating at 1. A history record is also removed, which frees its slot.
- R10: All three pointers move from slot i to slot i+1 and wrap from SLOTS-1 to 0. Each starts at slot 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_key | input | KEY_W | Page key of the request |
| req_ready | output | 1 | Block can take a request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Requested page was resident |
| resp_evict | output | 1 | A resident page was evicted |
| resp_victim | output | KEY_W | Key of the evicted page |
| resp_slot | output | $clog2(SLOTS) | Slot holding the requested page |
| cold_budget | output | $clog2(SLOTS+1) | Current cold-resident allocation |

## Verification
The bench builds the block with SLOTS=8 and KEY_W=8, so the resident capacity is four. With that capacity, a few dozen accesses fill the circle and force every pointer to wrap. The same sequence drives `cold_budget` to both saturation limits, 1 and 3. It also reaches the case where the test pointer must free a history slot before an insert. Expected victims and slots come from tracing the hand rules by hand over one fixed access sequence. The sequence covers promotion, double demotion and dropped untested pages.

// File: rtl/clockpro_replacer.sv
module clockpro_replacer #(
  parameter int SLOTS = 16,
  parameter int KEY_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [KEY_W-1:0]             req_key,
  output logic                         req_ready,
  output logic                         resp_valid,
  output logic                         resp_hit,
  output logic                         resp_evict,
  output logic [KEY_W-1:0]             resp_victim,
  output logic [$clog2(SLOTS)-1:0]     resp_slot,
  output logic [$clog2(SLOTS+1)-1:0]   cold_budget
);
  localparam int CAP   = SLOTS / 2;
  localparam int IDX_W = $clog2(SLOTS);
  localparam int CNT_W = $clog2(SLOTS + 1);

  typedef enum logic [1:0] {S_IDLE, S_COLD, S_PLACE, S_FIX} st_t;
  st_t st;

  logic [KEY_W-1:0] key_q [SLOTS];
  logic [SLOTS-1:0] vld_q, res_q, hot_q, ref_q, tst_q;
  logic [IDX_W-1:0] hand_c, hand_h, hand_t;
  logic [KEY_W-1:0] key_l;
  logic             rec_l;
  logic [IDX_W-1:0] rec_idx_l;

  logic             hit_any, rec_any, free_any;
  logic [IDX_W-1:0] hit_idx, rec_idx, free_idx;
  logic [CNT_W-1:0] n_res, n_hot;

  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] h);
    return (h == IDX_W'(SLOTS - 1)) ? '0 : h + IDX_W'(1);
  endfunction

  always_comb begin
    hit_any = 1'b0; hit_idx = '0;
    rec_any = 1'b0; rec_idx = '0;
    free_any = 1'b0; free_idx = '0;
    n_res = '0; n_hot = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (vld_q[i] && key_q[i] == req_key) begin
        if (res_q[i]) begin hit_any = 1'b1; hit_idx = IDX_W'(i); end
        else          begin rec_any = 1'b1; rec_idx = IDX_W'(i); end
      end
      if (!vld_q[i]) begin free_any = 1'b1; free_idx = IDX_W'(i); end
      n_res = n_res + CNT_W'(vld_q[i] & res_q[i]);
      n_hot = n_hot + CNT_W'(vld_q[i] & hot_q[i]);
    end
  end

  wire hot_excess = n_hot > (CNT_W'(CAP) - cold_budget);
  wire do_hot  = (st == S_COLD || st == S_FIX) && hot_excess;
  wire do_cold = (st == S_COLD) && !hot_excess;
  wire do_test = (st == S_PLACE) && !rec_l && !free_any;
  wire budget_up   = (st == S_PLACE) && rec_l && (cold_budget < CNT_W'(CAP - 1));
  wire test_closes = do_test && vld_q[hand_t] && !hot_q[hand_t] && tst_q[hand_t];

  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      for (int i = 0; i < SLOTS; i++) key_q[i] <= '0;
      vld_q <= '0; res_q <= '0; hot_q <= '0; ref_q <= '0; tst_q <= '0;
      hand_c <= '0; hand_h <= '0; hand_t <= '0;
      key_l <= '0; rec_l <= 1'b0; rec_idx_l <= '0;
      resp_valid <= 1'b0; resp_hit <= 1'b0; resp_evict <= 1'b0;
      resp_victim <= '0; resp_slot <= '0;
      cold_budget <= CNT_W'(1);
    end else begin
      resp_valid <= 1'b0;

      if (st == S_IDLE && req_valid) begin
        key_l <= req_key;
        resp_evict <= 1'b0;
        if (hit_any) begin
          ref_q[hit_idx] <= 1'b1;
          resp_hit   <= 1'b1;
          resp_slot  <= hit_idx;
          resp_valid <= 1'b1;
        end else begin
          resp_hit  <= 1'b0;
          rec_l     <= rec_any;
          rec_idx_l <= rec_idx;
          st <= (n_res == CNT_W'(CAP)) ? S_COLD : S_PLACE;
        end
      end

      if (do_hot) begin
        hand_h <= nxt(hand_h);
        if (vld_q[hand_h] && hot_q[hand_h]) begin
          if (ref_q[hand_h]) ref_q[hand_h] <= 1'b0;
          else begin
            hot_q[hand_h] <= 1'b0;
            tst_q[hand_h] <= 1'b0;
          end
        end
      end

      if (do_cold) begin
        hand_c <= nxt(hand_c);
        if (vld_q[hand_c] && res_q[hand_c] && !hot_q[hand_c]) begin
          if (ref_q[hand_c]) begin
            ref_q[hand_c] <= 1'b0;
            if (tst_q[hand_c]) begin
              hot_q[hand_c] <= 1'b1;
              tst_q[hand_c] <= 1'b0;
            end else begin
              tst_q[hand_c] <= 1'b1;
            end
          end else begin
            res_q[hand_c] <= 1'b0;
            if (!tst_q[hand_c]) vld_q[hand_c] <= 1'b0;
            resp_evict  <= 1'b1;
            resp_victim <= key_q[hand_c];
            st <= S_PLACE;
          end
        end
      end

      if (do_test) begin
        hand_t <= nxt(hand_t);
        if (test_closes) begin
          tst_q[hand_t] <= 1'b0;
          if (!res_q[hand_t]) vld_q[hand_t] <= 1'b0;
        end
      end

      if (budget_up) cold_budget <= cold_budget + CNT_W'(1);
      else if (test_closes && cold_budget > CNT_W'(1)) cold_budget <= cold_budget - CNT_W'(1);

      if (st == S_PLACE) begin
        if (rec_l) begin
          res_q[rec_idx_l] <= 1'b1;
          hot_q[rec_idx_l] <= 1'b1;
          tst_q[rec_idx_l] <= 1'b0;
          ref_q[rec_idx_l] <= 1'b0;
          resp_slot <= rec_idx_l;
          st <= S_FIX;
        end else if (free_any) begin
          key_q[free_idx] <= key_l;
          vld_q[free_idx] <= 1'b1;
          res_q[free_idx] <= 1'b1;
          hot_q[free_idx] <= 1'b0;
          tst_q[free_idx] <= 1'b1;
          ref_q[free_idx] <= 1'b0;
          resp_slot <= free_idx;
          st <= S_FIX;
        end
      end

      if (st == S_FIX && !hot_excess) begin
        resp_valid <= 1'b1;
        st <= S_IDLE;
      end
    end
  end
endmodule

// File: rtl/clockpro_replacer_chk.sv
module clockpro_replacer_chk #(
  parameter int SLOTS = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_ready,
  input logic                       resp_valid,
  input logic                       resp_hit,
  input logic                       resp_evict,
  input logic [$clog2(SLOTS+1)-1:0] cold_budget
);
  localparam int CAP   = SLOTS / 2;
  localparam int CNT_W = $clog2(SLOTS + 1);

  p_hit_no_victim_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> !resp_evict);

  p_ready_on_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> req_ready);

  p_budget_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cold_budget >= CNT_W'(1)) && (cold_budget <= CNT_W'(CAP - 1)));

  p_budget_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cold_budget == $past(cold_budget)) ||
    (cold_budget == $past(cold_budget) + CNT_W'(1)) ||
    (cold_budget + CNT_W'(1) == $past(cold_budget)));
endmodule

bind clockpro_replacer clockpro_replacer_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
  .resp_hit(resp_hit), .resp_evict(resp_evict), .cold_budget(cold_budget)
);

// File: tb/test_clockpro_replacer.sv
`timescale 1ns/1ps
module test_clockpro_replacer;
  localparam int SLOTS = 8;
  localparam int KEY_W = 8;
  localparam int IDX_W = $clog2(SLOTS);
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [KEY_W-1:0] req_key = '0;
  logic req_ready, resp_valid, resp_hit, resp_evict;
  logic [KEY_W-1:0] resp_victim;
  logic [IDX_W-1:0] resp_slot;
  logic [CNT_W-1:0] cold_budget;
  int tests = 0, fails = 0;

  clockpro_replacer #(.SLOTS(SLOTS), .KEY_W(KEY_W)) i_clockpro_replacer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_key(req_key),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_evict(resp_evict), .resp_victim(resp_victim), .resp_slot(resp_slot),
    .cold_budget(cold_budget));

  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic access(input int key, input bit e_hit, input bit e_ev, input int e_vic,
                        input int e_slot, input int e_bud, input string req, input bit chk_busy);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_key = KEY_W'(key);
    @(negedge clk);
    req_valid = 1'b0;
    if (chk_busy) check(req, "ready low during miss", int'(req_ready), 0);
    n = 0;
    while (!resp_valid && n < 200) begin @(negedge clk); n++; end
    check(req, "response seen", int'(resp_valid), 1);
    check(req, "hit", int'(resp_hit), int'(e_hit));
    check(req, "evict", int'(resp_evict), int'(e_ev));
    if (e_ev) check(req, "victim key", int'(resp_victim), e_vic);
    check(req, "slot", int'(resp_slot), e_slot);
    check(req, "cold budget", int'(cold_budget), e_bud);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", int'(req_ready), 1);
    check("R1", "no response after reset", int'(resp_valid), 0);
    check("R1", "budget after reset", int'(cold_budget), 1);
  endtask

  task automatic t_fill;
    access(10, 0, 0, 0, 0, 1, "R1", 1);
    access(11, 0, 0, 0, 1, 1, "R4", 1);
    access(12, 0, 0, 0, 2, 1, "R4", 0);
    access(13, 0, 0, 0, 3, 1, "R4", 0);
  endtask

  task automatic t_hits;
    access(11, 1, 0, 0, 1, 1, "R2", 0);
  endtask

  task automatic t_first_evict;
    access(20, 0, 1, 10, 4, 1, "R5", 1);
  endtask

  task automatic t_record_and_promote;
    // R6: 11 promoted (ref set, in test), so 12 is the victim; R8: 10 revives in slot 0
    access(10, 0, 1, 12, 0, 2, "R8", 0);
    access(13, 1, 0, 0, 3, 2, "R2", 0);
    access(10, 1, 0, 0, 0, 2, "R2", 0);
    // R7: promotion of 13 forces demotion of 11; R10: cold hand continues to 20
    access(30, 0, 1, 20, 5, 2, "R6", 0);
  endtask

  task automatic t_test_hand;
    access(40, 0, 1, 30, 6, 2, "R10", 0);
    access(41, 0, 1, 40, 7, 2, "R5", 0);
    // no empty slot: test hand removes record 12 and lowers budget
    access(42, 0, 1, 41, 2, 1, "R9", 0);
  endtask

  task automatic t_untested_drop;
    // 11 was demoted outside a test window: evicted and dropped
    access(43, 0, 1, 11, 1, 1, "R7", 0);
    // 11 has no record: plain miss; test hand frees 20, budget floors at 1
    access(11, 0, 1, 42, 4, 1, "R9", 0);
  endtask

  task automatic t_budget_ceiling;
    access(30, 0, 1, 11, 5, 2, "R8", 0);
    access(40, 0, 1, 43, 6, 3, "R7", 0);
    access(41, 0, 1, 13, 7, 3, "R8", 0);
    access(41, 1, 0, 0, 7, 3, "R2", 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_fill();
    t_hits();
    t_first_evict();
    t_record_and_promote();
    t_test_hand();
    t_untested_drop();
    t_budget_ceiling();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule